// File: doc/BRIEF.md
# SMBus Protocol Transaction Sequencer

This block expands a single start request into the ordered list of byte-level operations that one SMBus protocol needs. A byte-level bus engine outside the block handles each operation: start with write, start with read, send a byte, receive a byte followed by ACK or NACK, and stop. The block issues these operations one at a time over a valid/ready request channel. It waits for a response carrying an acknowledge flag and, for receives, a data byte.

The host register file supplies the inputs: the protocol code, the address byte, command, data0, data1, a buffer-mode select, the current device-error status bit and a block write buffer. When the sequence ends, the block returns results as one-cycle write strobes for data0, data1 and the block data byte. It also raises one-cycle set pulses for the interrupt, device-error, host-busy and byte-done status bits. Incoming block bytes go into a local receive buffer. An I2C-style block read leaves the bus open after its first byte. The block keeps that state visible until the next start, which closes the bus before doing anything else.

Top module: `smbus_seq`

## Requirements
- R1: Protocol 0 (quick) issues one start whose byte is {addr[7:1], addr[0]}, with op 1 (start-read) when addr[0]=1 and op 0 (start-write) when addr[0]=0. It then issues stop (op 5) and pulses set_intr.
- R2: Protocol 1 write issues start-write, then send (op 2) of cmd, then stop. Protocol 1 read issues start-read, then receive-NACK (op 4), then stop. The read writes the received byte to data0 through d0_we/d0_out. Both directions pulse set_intr.
- R3: Protocol 2 write sends cmd and then data0. Protocol 2 read sends cmd, issues a repeated start-read and a receive-NACK, and returns the byte in data0. Both directions pulse set_intr.
- R4: Protocol 3 write sends cmd, then data0 (low byte), then data1 (high byte). Protocol 3 read receives the first byte with receive-ACK (op 3) into data0 and the second with receive-NACK into data1.
- R5: Any of these issues no bus operation and pulses set_dev_err in the cycle after the start: protocol codes 4 and 7, or a buffer-mode block write whose data0 count exceeds MAX_BLK.
- R6: A start that arrives while dev_err_in is 1 issues no bus operation and pulses set_dev_err in the next cycle.
- R7: An operation other than stop that comes back with rsp_ack=0 ends the sequence with one stop. It then pulses set_dev_err, and does not pulse set_intr or any data strobe.
- R8: Protocol 6 ignores addr[0]. It issues start-write {addr[7:1],0}, sends data1 as the offset, issues start-read {addr[7:1],1} and a receive-ACK. The byte goes to the block data strobe, with set_host_busy and set_byte_done pulsed and no stop. in_blkrd then stays 1.
- R9: A start accepted while in_blkrd=1 first issues a stop and clears in_blkrd, then runs the requested protocol.
- R10: Protocol 5 read sends cmd, issues start-read and receives a count byte with receive-ACK. It then receives that many bytes into blk_rd_buf (byte i at bits 8i+7:8i), the last one with receive-NACK, and writes the count to data0. Buffer mode pulses set_intr. Otherwise it outputs byte 0 on the block data strobe and pulses set_host_busy and set_byte_done. A count above MAX_BLK gives stop and set_dev_err.
- R11: Protocol 5 write in buffer mode sends cmd, data0 as the count, then data0 bytes from blk_wr_buf, then stop, and pulses set_intr. Without buffer mode it issues no bus operation and pulses set_host_busy and set_byte_done.
- R12: busy is 1 from the cycle after an accepted start through the cycle of the result pulses. A start while busy is ignored, and no request is raised while busy is 0.
- R13: A request holds req_valid, req_op and req_data stable until req_ready, and no new request is raised until the response arrives. req_data is meaningful for ops 0, 1 and 2 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start request, taken when idle |
| proto | input | 3 | Protocol code |
| addr_reg | input | 8 | Target address [7:1], read flag [0] |
| cmd | input | 8 | Command byte |
| data0 | input | 8 | Data register 0 / block count |
| data1 | input | 8 | Data register 1 / block-read offset |
| buf_mode | input | 1 | Whole-block buffer mode |
| dev_err_in | input | 1 | Current device-error status |
| blk_wr_buf | input | 8*MAX_BLK | Block write bytes, byte i at [8i+7:8i] |
| busy | output | 1 | Sequence in progress |
| in_blkrd | output | 1 | Open I2C-style block read |
| req_valid | output | 1 | Byte operation request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 3 | Operation code 0..5 |
| req_data | output | 8 | Start or send byte |
| rsp_valid | input | 1 | Response valid |
| rsp_ack | input | 1 | 1 = acknowledged / no bus fault |
| rsp_data | input | 8 | Received byte |
| set_intr | output | 1 | Pulse: set interrupt status |
| set_dev_err | output | 1 | Pulse: set device-error status |
| set_host_busy | output | 1 | Pulse: set host-busy status |
| set_byte_done | output | 1 | Pulse: set byte-done status |
| d0_we | output | 1 | Write strobe for data0 |
| d0_out | output | 8 | data0 result |
| d1_we | output | 1 | Write strobe for data1 |
| d1_out | output | 8 | data1 result |
| blk_we | output | 1 | Write strobe for block data byte |
| blk_out | output | 8 | Block data byte |
| blk_rd_buf | output | 8*MAX_BLK | Received block bytes |

## Verification
A wrong step index or protocol decode shows up at the request port as soon as the faulty operation is raised. The scoreboard compares every request against the expected list, so a missing, extra or reordered byte is seen at that same request. A corrupted error flag or block counter shows up a few cycles later as a forced stop, a missing NACK on the last receive, or the wrong status pulse in the final cycle. A stale open-block-read flag shows up at the next start, as a missing or unexpected leading stop.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    // byte-level operations toward the bus engine
    typedef enum logic [2:0] {
        BOP_START_W   = 3'd0,
        BOP_START_R   = 3'd1,
        BOP_SEND      = 3'd2,
        BOP_RECV_ACK  = 3'd3,
        BOP_RECV_NACK = 3'd4,
        BOP_STOP      = 3'd5
    } bus_op_e;

    // micro steps of a protocol program
    typedef enum logic [3:0] {
        U_STW, U_STR, U_SCMD, U_SD0, U_SD1, U_SOFF,
        U_RD0L, U_RD0A, U_RD1L, U_RCNT,
        U_BLKS, U_BLKR, U_RFIRST, U_STOP, U_END, U_HOLD
    } uop_e;

    typedef enum logic [1:0] {
        S_IDLE, S_CLOSE, S_RUN, S_FIN
    } seq_st_e;

    localparam logic [2:0] P_QUICK = 3'd0;
    localparam logic [2:0] P_BYTE  = 3'd1;
    localparam logic [2:0] P_BDATA = 3'd2;
    localparam logic [2:0] P_WORD  = 3'd3;
    localparam logic [2:0] P_PCALL = 3'd4;
    localparam logic [2:0] P_BLOCK = 3'd5;
    localparam logic [2:0] P_I2CBR = 3'd6;
    localparam logic [2:0] P_RSVD  = 3'd7;

endpackage

// File: rtl/smbus_step_dec.sv
module smbus_step_dec
    import smbus_seq_pkg::*;
(
    input  logic [2:0] proto,
    input  logic       rd,
    input  logic [2:0] step,
    output uop_e       uop
);
    always_comb begin
        uop = U_END;
        case (proto)
            P_QUICK: case (step)
                3'd0:    uop = rd ? U_STR : U_STW;
                3'd1:    uop = U_STOP;
                default: uop = U_END;
            endcase
            P_BYTE: case (step)
                3'd0:    uop = rd ? U_STR : U_STW;
                3'd1:    uop = rd ? U_RD0L : U_SCMD;
                3'd2:    uop = U_STOP;
                default: uop = U_END;
            endcase
            P_BDATA: case (step)
                3'd0:    uop = U_STW;
                3'd1:    uop = U_SCMD;
                3'd2:    uop = rd ? U_STR : U_SD0;
                3'd3:    uop = rd ? U_RD0L : U_STOP;
                3'd4:    uop = rd ? U_STOP : U_END;
                default: uop = U_END;
            endcase
            P_WORD: case (step)
                3'd0:    uop = U_STW;
                3'd1:    uop = U_SCMD;
                3'd2:    uop = rd ? U_STR : U_SD0;
                3'd3:    uop = rd ? U_RD0A : U_SD1;
                3'd4:    uop = rd ? U_RD1L : U_STOP;
                3'd5:    uop = rd ? U_STOP : U_END;
                default: uop = U_END;
            endcase
            P_BLOCK: case (step)
                3'd0:    uop = U_STW;
                3'd1:    uop = U_SCMD;
                3'd2:    uop = rd ? U_STR : U_SD0;
                3'd3:    uop = rd ? U_RCNT : U_BLKS;
                3'd4:    uop = rd ? U_BLKR : U_STOP;
                3'd5:    uop = rd ? U_STOP : U_END;
                default: uop = U_END;
            endcase
            P_I2CBR: case (step)
                3'd0:    uop = U_STW;
                3'd1:    uop = U_SOFF;
                3'd2:    uop = U_STR;
                3'd3:    uop = U_RFIRST;
                default: uop = U_HOLD;
            endcase
            default: uop = U_END;
        endcase
    end
endmodule

// File: rtl/smbus_op_enc.sv
module smbus_op_enc
    import smbus_seq_pkg::*;
(
    input  uop_e       uop,
    input  logic [6:0] addr7,
    input  logic [7:0] cmd,
    input  logic [7:0] d0,
    input  logic [7:0] d1,
    input  logic [7:0] wr_byte,
    input  logic       last,
    output logic       is_bus,
    output bus_op_e    op,
    output logic [7:0] data
);
    always_comb begin
        is_bus = 1'b1;
        op     = BOP_STOP;
        data   = 8'h00;
        case (uop)
            U_STW:    begin op = BOP_START_W;   data = {addr7, 1'b0}; end
            U_STR:    begin op = BOP_START_R;   data = {addr7, 1'b1}; end
            U_SCMD:   begin op = BOP_SEND;      data = cmd;           end
            U_SD0:    begin op = BOP_SEND;      data = d0;            end
            U_SD1,
            U_SOFF:   begin op = BOP_SEND;      data = d1;            end
            U_BLKS:   begin op = BOP_SEND;      data = wr_byte;       end
            U_RD0A,
            U_RCNT,
            U_RFIRST: op = BOP_RECV_ACK;
            U_RD0L,
            U_RD1L:   op = BOP_RECV_NACK;
            U_BLKR:   op = last ? BOP_RECV_NACK : BOP_RECV_ACK;
            U_STOP:   op = BOP_STOP;
            default:  is_bus = 1'b0;
        endcase
    end
endmodule

// File: rtl/smbus_rx_buf.sv
module smbus_rx_buf #(
    parameter int DEPTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [7:0]         widx,
    input  logic [7:0]         wdata,
    output logic [DEPTH*8-1:0] rd_flat
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [7:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      ent_q <= 8'h00;
            else if (we && widx == 8'(i))    ent_q <= wdata;
        end
        assign rd_flat[i*8 +: 8] = ent_q;
    end
endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
    import smbus_seq_pkg::*;
#(
    parameter int MAX_BLK = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           proto,
    input  logic [7:0]           addr_reg,
    input  logic [7:0]           cmd,
    input  logic [7:0]           data0,
    input  logic [7:0]           data1,
    input  logic                 buf_mode,
    input  logic                 dev_err_in,
    input  logic [MAX_BLK*8-1:0] blk_wr_buf,
    output logic                 busy,
    output logic                 in_blkrd,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [2:0]           req_op,
    output logic [7:0]           req_data,
    input  logic                 rsp_valid,
    input  logic                 rsp_ack,
    input  logic [7:0]           rsp_data,
    output logic                 set_intr,
    output logic                 set_dev_err,
    output logic                 set_host_busy,
    output logic                 set_byte_done,
    output logic                 d0_we,
    output logic [7:0]           d0_out,
    output logic                 d1_we,
    output logic [7:0]           d1_out,
    output logic                 blk_we,
    output logic [7:0]           blk_out,
    output logic [MAX_BLK*8-1:0] blk_rd_buf
);
    localparam logic [7:0] MAX_CNT = 8'(MAX_BLK);

    typedef struct packed {
        seq_st_e    st;
        logic       waiting;
        logic [2:0] step;
        logic [7:0] idx;
        logic [7:0] cnt;
        logic [2:0] proto;
        logic       rd;
        logic [6:0] addr7;
        logic [7:0] cmd;
        logic [7:0] d0;
        logic [7:0] d1;
        logic       bufm;
        logic       err;
        logic       inblk;
        logic [7:0] r0;
        logic [7:0] r1;
        logic [7:0] rb;
    } seq_t;

    seq_t q, d;

    uop_e       dec_uop, uop;
    logic       enc_bus, bus_now, loop_done, last_rx, rbuf_we;
    bus_op_e    enc_op;
    logic [7:0] enc_data, wr_byte;

    function automatic seq_st_e entry_state(logic err, logic [2:0] p, logic r, logic bm);
        if (err)                          return S_FIN;
        else if (p == P_BLOCK && !r && !bm) return S_FIN;
        else                              return S_RUN;
    endfunction

    smbus_step_dec u_dec (
        .proto (q.proto),
        .rd    (q.rd),
        .step  (q.step),
        .uop   (dec_uop)
    );

    // a fault redirects the program to its closing stop
    assign uop       = q.err ? U_STOP : dec_uop;
    assign wr_byte   = blk_wr_buf[int'(q.idx)*8 +: 8];
    assign last_rx   = (q.idx == q.cnt - 8'd1);
    assign loop_done = (uop == U_BLKS && q.idx == q.d0) ||
                       (uop == U_BLKR && q.idx == q.cnt);

    smbus_op_enc u_enc (
        .uop     (uop),
        .addr7   (q.addr7),
        .cmd     (q.cmd),
        .d0      (q.d0),
        .d1      (q.d1),
        .wr_byte (wr_byte),
        .last    (last_rx),
        .is_bus  (enc_bus),
        .op      (enc_op),
        .data    (enc_data)
    );

    assign bus_now = enc_bus && !loop_done;

    smbus_rx_buf #(.DEPTH(MAX_BLK)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rbuf_we),
        .widx    (q.idx),
        .wdata   (rsp_data),
        .rd_flat (blk_rd_buf)
    );

    always_comb begin
        d       = q;
        rbuf_we = 1'b0;
        case (q.st)
            S_IDLE: if (start) begin
                d.proto   = proto;
                d.rd      = addr_reg[0];
                d.addr7   = addr_reg[7:1];
                d.cmd     = cmd;
                d.d0      = data0;
                d.d1      = data1;
                d.bufm    = buf_mode;
                d.step    = 3'd0;
                d.idx     = 8'd0;
                d.cnt     = 8'd0;
                d.waiting = 1'b0;
                d.err     = dev_err_in || proto == P_PCALL || proto == P_RSVD ||
                            (proto == P_BLOCK && !addr_reg[0] && buf_mode && data0 > MAX_CNT);
                d.st      = q.inblk ? S_CLOSE
                                    : entry_state(d.err, proto, addr_reg[0], buf_mode);
            end
            S_CLOSE: begin
                if (!q.waiting) begin
                    if (req_ready) d.waiting = 1'b1;
                end else if (rsp_valid) begin
                    d.waiting = 1'b0;
                    d.inblk   = 1'b0;
                    d.st      = entry_state(q.err, q.proto, q.rd, q.bufm);
                end
            end
            S_RUN: begin
                if (!bus_now) begin
                    if (uop == U_END)       d.st = S_FIN;
                    else if (uop == U_HOLD) begin d.st = S_FIN; d.inblk = 1'b1; end
                    else                    d.step = q.step + 3'd1;
                end else if (!q.waiting) begin
                    if (req_ready) d.waiting = 1'b1;
                end else if (rsp_valid) begin
                    d.waiting = 1'b0;
                    if (uop == U_STOP) begin
                        if (q.err) d.st = S_FIN;
                        else       d.step = q.step + 3'd1;
                    end else if (!rsp_ack) begin
                        d.err = 1'b1;
                    end else begin
                        case (uop)
                            U_RD0L, U_RD0A: begin d.r0 = rsp_data; d.step = q.step + 3'd1; end
                            U_RD1L:   begin d.r1 = rsp_data; d.step = q.step + 3'd1; end
                            U_RFIRST: begin d.rb = rsp_data; d.step = q.step + 3'd1; end
                            U_RCNT: begin
                                d.cnt = rsp_data;
                                if (rsp_data > MAX_CNT) d.err  = 1'b1;
                                else                    d.step = q.step + 3'd1;
                            end
                            U_BLKS: d.idx = q.idx + 8'd1;
                            U_BLKR: begin
                                rbuf_we = 1'b1;
                                if (q.idx == 8'd0) d.rb = rsp_data;
                                d.idx = q.idx + 8'd1;
                            end
                            default: d.step = q.step + 3'd1;
                        endcase
                    end
                end
            end
            S_FIN: begin
                d.st  = S_IDLE;
                d.err = 1'b0;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic fin, ok, is_p5, is_p6, rd_res;
    assign fin    = (q.st == S_FIN);
    assign ok     = fin && !q.err;
    assign is_p5  = (q.proto == P_BLOCK);
    assign is_p6  = (q.proto == P_I2CBR);
    assign rd_res = q.rd && (q.proto == P_BYTE || q.proto == P_BDATA ||
                             q.proto == P_WORD || is_p5);

    assign busy          = (q.st != S_IDLE);
    assign in_blkrd      = q.inblk;
    assign req_valid     = !q.waiting && (q.st == S_CLOSE || (q.st == S_RUN && bus_now));
    assign req_op        = (q.st == S_CLOSE) ? 3'(BOP_STOP) : 3'(enc_op);
    assign req_data      = (q.st == S_CLOSE) ? 8'h00 : enc_data;
    assign set_dev_err   = fin && q.err;
    assign set_intr      = ok && !is_p6 && !(is_p5 && !q.bufm);
    assign set_host_busy = ok && (is_p6 || (is_p5 && !q.bufm));
    assign set_byte_done = set_host_busy;
    assign d0_we         = ok && rd_res;
    assign d0_out        = is_p5 ? q.cnt : q.r0;
    assign d1_we         = ok && q.rd && q.proto == P_WORD;
    assign d1_out        = q.r1;
    assign blk_we        = ok && (is_p6 || (is_p5 && q.rd && !q.bufm));
    assign blk_out       = q.rb;

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_data));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);
    // R12
    pulse_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_intr || set_dev_err || set_host_busy) |-> busy);
    // R7
    intr_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_intr && set_dev_err));
    // R6
    pre_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !in_blkrd && dev_err_in |=> set_dev_err && !req_valid);
    // R5
    bad_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !in_blkrd && (proto == 3'd4 || proto == 3'd7) |=> set_dev_err && !req_valid);

endmodule

// File: tb/sim_smbus_seq.sv
module sim_smbus_seq;
    localparam int MB = 32;
    localparam logic [2:0] O_SW = 0, O_SR = 1, O_SD = 2, O_RA = 3, O_RN = 4, O_SP = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, buf_mode = 0, dev_err_in = 0;
    logic [2:0] proto = 0;
    logic [7:0] addr_reg = 0, cmd = 0, data0 = 0, data1 = 0;
    logic [MB*8-1:0] blk_wr_buf = '0;
    logic busy, in_blkrd, req_valid, req_ready = 0, rsp_valid = 0, rsp_ack = 0;
    logic [2:0] req_op;
    logic [7:0] req_data, rsp_data = 0;
    logic set_intr, set_dev_err, set_host_busy, set_byte_done;
    logic d0_we, d1_we, blk_we;
    logic [7:0] d0_out, d1_out, blk_out;
    logic [MB*8-1:0] blk_rd_buf;

    always #5 clk = ~clk;

    smbus_seq #(.MAX_BLK(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .proto(proto), .addr_reg(addr_reg),
        .cmd(cmd), .data0(data0), .data1(data1), .buf_mode(buf_mode),
        .dev_err_in(dev_err_in), .blk_wr_buf(blk_wr_buf), .busy(busy),
        .in_blkrd(in_blkrd), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_data(req_data), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_data(rsp_data), .set_intr(set_intr),
        .set_dev_err(set_dev_err), .set_host_busy(set_host_busy),
        .set_byte_done(set_byte_done), .d0_we(d0_we), .d0_out(d0_out),
        .d1_we(d1_we), .d1_out(d1_out), .blk_we(blk_we), .blk_out(blk_out),
        .blk_rd_buf(blk_rd_buf)
    );

    int checks = 0, errors = 0;
    string tag = "reset";
    logic [10:0] exp_q[$];
    logic [7:0]  rx_q[$];
    int nack_at = -1;

    task automatic chk(input bit good, input string t, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
        end
    endtask

    task automatic ex(input logic [2:0] op, input logic [7:0] dt);
        exp_q.push_back({op, dt});
    endtask

    // result monitor
    logic g_intr, g_err, g_hb, g_bd, g_d0, g_d1, g_blk;
    logic [7:0] v_d0, v_d1, v_blk;
    initial forever begin
        @(negedge clk);
        if (set_intr)      g_intr = 1;
        if (set_dev_err)   g_err  = 1;
        if (set_host_busy) g_hb   = 1;
        if (set_byte_done) g_bd   = 1;
        if (d0_we)  begin g_d0  = 1; v_d0  = d0_out;  end
        if (d1_we)  begin g_d1  = 1; v_d1  = d1_out;  end
        if (blk_we) begin g_blk = 1; v_blk = blk_out; end
    end

    // byte engine model and scoreboard
    initial begin : engine
        logic [10:0] e;
        logic        a;
        logic [7:0]  r;
        a = 1; r = 0;
        forever begin
            @(negedge clk);
            if (rsp_valid) rsp_valid = 0;
            else if (req_ready) begin
                req_ready = 0; rsp_valid = 1; rsp_ack = a; rsp_data = r;
            end else if (req_valid) begin
                if (exp_q.size() == 0)
                    chk(0, {tag, " unexpected request"}, int'(req_op), 7);
                else begin
                    e = exp_q.pop_front();
                    chk(req_op == e[10:8] && (req_op > O_SD || req_data == e[7:0]),
                        {tag, " bus op"}, int'({req_op, req_data}), int'(e));
                end
                a = 1; r = 8'h00;
                if (req_op != O_SP) begin
                    if (nack_at == 0) a = 0;
                    if (nack_at >= 0) nack_at--;
                end
                if ((req_op == O_RA || req_op == O_RN) && rx_q.size() > 0) r = rx_q.pop_front();
                req_ready = 1;
            end
        end
    end

    task automatic run(input logic [2:0] p, input logic [7:0] a, c, x0, x1,
                       input logic bm, input logic de);
        @(negedge clk);
        proto = p; addr_reg = a; cmd = c; data0 = x0; data1 = x1;
        buf_mode = bm; dev_err_in = de; start = 1;
        {g_intr, g_err, g_hb, g_bd, g_d0, g_d1, g_blk} = '0;
        @(negedge clk);
        start = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " missing bus ops"}, exp_q.size(), 0);
        exp_q.delete(); rx_q.delete(); nack_at = -1; dev_err_in = 0;
    endtask

    task automatic flags(input logic i, er, hb, bd);
        chk({g_intr, g_err, g_hb, g_bd} == {i, er, hb, bd}, {tag, " status pulses"},
            int'({g_intr, g_err, g_hb, g_bd}), int'({i, er, hb, bd}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !req_valid && !in_blkrd, "R12 reset state", int'({busy, req_valid, in_blkrd}), 0);

        tag = "R1 quick write"; ex(O_SW, 8'hA0); ex(O_SP, 0);
        run(0, 8'hA0, 0, 0, 0, 0, 0); flags(1, 0, 0, 0);
        tag = "R1 quick read"; ex(O_SR, 8'hA1); ex(O_SP, 0);
        run(0, 8'hA1, 0, 0, 0, 0, 0); flags(1, 0, 0, 0);

        tag = "R2 byte write"; ex(O_SW, 8'h20); ex(O_SD, 8'h3C); ex(O_SP, 0);
        run(1, 8'h20, 8'h3C, 0, 0, 0, 0); flags(1, 0, 0, 0);
        tag = "R2 byte read"; ex(O_SR, 8'h21); ex(O_RN, 0); ex(O_SP, 0); rx_q.push_back(8'h5A);
        run(1, 8'h21, 0, 0, 0, 0, 0); flags(1, 0, 0, 0);
        chk(g_d0 && v_d0 == 8'h5A, "R2 data0", v_d0, 8'h5A);

        tag = "R3 byte-data write"; ex(O_SW, 8'h40); ex(O_SD, 8'h11); ex(O_SD, 8'h99); ex(O_SP, 0);
        run(2, 8'h40, 8'h11, 8'h99, 0, 0, 0); flags(1, 0, 0, 0);
        tag = "R3 byte-data read"; ex(O_SW, 8'h40); ex(O_SD, 8'h12); ex(O_SR, 8'h41);
        ex(O_RN, 0); ex(O_SP, 0); rx_q.push_back(8'hC3);
        run(2, 8'h41, 8'h12, 0, 0, 0, 0); flags(1, 0, 0, 0);
        chk(g_d0 && v_d0 == 8'hC3, "R3 data0", v_d0, 8'hC3);

        tag = "R4 word write"; ex(O_SW, 8'h50); ex(O_SD, 8'h07); ex(O_SD, 8'hCD); ex(O_SD, 8'hAB); ex(O_SP, 0);
        run(3, 8'h50, 8'h07, 8'hCD, 8'hAB, 0, 0); flags(1, 0, 0, 0);
        tag = "R4 word read"; ex(O_SW, 8'h50); ex(O_SD, 8'h08); ex(O_SR, 8'h51);
        ex(O_RA, 0); ex(O_RN, 0); ex(O_SP, 0); rx_q.push_back(8'h34); rx_q.push_back(8'h12);
        run(3, 8'h51, 8'h08, 0, 0, 0, 0); flags(1, 0, 0, 0);
        chk(g_d0 && g_d1 && v_d0 == 8'h34 && v_d1 == 8'h12, "R4 data0/data1", int'({v_d1, v_d0}), 16'h1234);

        tag = "R5 code 4"; run(4, 8'h50, 0, 0, 0, 0, 0); flags(0, 1, 0, 0);
        tag = "R5 code 7"; run(7, 8'h50, 0, 0, 0, 0, 0); flags(0, 1, 0, 0);
        tag = "R5 block count over limit"; run(5, 8'h50, 0, 8'(MB + 1), 0, 1, 0); flags(0, 1, 0, 0);

        tag = "R6 dev err preset"; run(1, 8'h21, 0, 0, 0, 0, 1); flags(0, 1, 0, 0);
        chk(!g_d0, "R6 no data0 write", g_d0, 0);

        tag = "R7 address nack"; nack_at = 0; ex(O_SW, 8'h60); ex(O_SP, 0);
        run(2, 8'h60, 8'h01, 8'h02, 0, 0, 0); flags(0, 1, 0, 0);
        tag = "R7 data nack"; nack_at = 3; ex(O_SW, 8'h60); ex(O_SD, 8'h01);
        ex(O_SD, 8'h02); ex(O_SD, 8'h03); ex(O_SP, 0);
        run(3, 8'h60, 8'h01, 8'h02, 8'h03, 0, 0); flags(0, 1, 0, 0);
        tag = "R7 read nack"; nack_at = 1; ex(O_SR, 8'h61); ex(O_RN, 0); ex(O_SP, 0);
        run(1, 8'h61, 0, 0, 0, 0, 0); flags(0, 1, 0, 0);
        chk(!g_d0, "R7 no data0 write", g_d0, 0);

        blk_wr_buf[7:0] = 8'h10; blk_wr_buf[15:8] = 8'h20; blk_wr_buf[23:16] = 8'h30;
        tag = "R11 block write buffered"; ex(O_SW, 8'h70); ex(O_SD, 8'h44); ex(O_SD, 8'h03);
        ex(O_SD, 8'h10); ex(O_SD, 8'h20); ex(O_SD, 8'h30); ex(O_SP, 0);
        run(5, 8'h70, 8'h44, 8'h03, 0, 1, 0); flags(1, 0, 0, 0);
        tag = "R11 block write bytewise"; run(5, 8'h70, 8'h44, 8'h03, 0, 0, 0); flags(0, 0, 1, 1);

        tag = "R10 block read buffered"; ex(O_SW, 8'h70); ex(O_SD, 8'h45); ex(O_SR, 8'h71);
        ex(O_RA, 0); ex(O_RA, 0); ex(O_RA, 0); ex(O_RA, 0); ex(O_RN, 0); ex(O_SP, 0);
        rx_q = '{8'h04, 8'h11, 8'h22, 8'h33, 8'h44};
        run(5, 8'h71, 8'h45, 0, 0, 1, 0); flags(1, 0, 0, 0);
        chk(g_d0 && v_d0 == 8'h04, "R10 count in data0", v_d0, 4);
        chk(blk_rd_buf[31:0] == 32'h44332211, "R10 buffer bytes", blk_rd_buf[31:0], 32'h44332211);
        tag = "R10 block read bytewise"; ex(O_SW, 8'h70); ex(O_SD, 8'h46); ex(O_SR, 8'h71);
        ex(O_RA, 0); ex(O_RA, 0); ex(O_RN, 0); ex(O_SP, 0);
        rx_q = '{8'h02, 8'hAA, 8'hBB};
        run(5, 8'h71, 8'h46, 0, 0, 0, 0); flags(0, 0, 1, 1);
        chk(g_blk && v_blk == 8'hAA && v_d0 == 8'h02, "R10 byte0 presented", int'({v_d0, v_blk}), 16'h02AA);
        tag = "R10 count overflow"; ex(O_SW, 8'h70); ex(O_SD, 8'h47); ex(O_SR, 8'h71);
        ex(O_RA, 0); ex(O_SP, 0); rx_q.push_back(8'(MB + 8));
        run(5, 8'h71, 8'h47, 0, 0, 1, 0); flags(0, 1, 0, 0);

        tag = "R8 i2c block read"; ex(O_SW, 8'h80); ex(O_SD, 8'h08); ex(O_SR, 8'h81); ex(O_RA, 0);
        rx_q.push_back(8'h77);
        run(6, 8'h81, 8'h00, 0, 8'h08, 0, 0); flags(0, 0, 1, 1);
        chk(g_blk && v_blk == 8'h77, "R8 first byte", v_blk, 8'h77);
        chk(in_blkrd == 1'b1, "R8 open state", in_blkrd, 1);

        tag = "R9 close on next start"; ex(O_SP, 0); ex(O_SW, 8'h30); ex(O_SP, 0);
        run(0, 8'h30, 0, 0, 0, 0, 0); flags(1, 0, 0, 0);
        chk(in_blkrd == 1'b0, "R9 open state cleared", in_blkrd, 0);

        // start while busy must be ignored
        tag = "R12 start while busy"; ex(O_SW, 8'h90); ex(O_SD, 8'h01); ex(O_SD, 8'h02); ex(O_SD, 8'h03); ex(O_SP, 0);
        @(negedge clk);
        proto = 3; addr_reg = 8'h90; cmd = 8'h01; data0 = 8'h02; data1 = 8'h03; buf_mode = 0; start = 1;
        {g_intr, g_err, g_hb, g_bd, g_d0, g_d1, g_blk} = '0;
        @(negedge clk); start = 0;
        chk(busy == 1'b1, "R12 busy after start", busy, 1);
        repeat (2) @(negedge clk);
        proto = 0; addr_reg = 8'hF1; start = 1;
        @(negedge clk); start = 0;
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && !req_valid, "R12 ignored start", exp_q.size(), 0);
        flags(1, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule